// File: doc/BRIEF.md
# UART FIFO-Mode Interrupt Priority Encoder

This block produces the single interrupt line and the 4-bit interrupt identification code of a 16550-style serial port operating with its FIFOs enabled. It takes the interrupt enable bits and the receive FIFO fill count. It also takes a 2-bit trigger-level select, the receive line-error and character-timeout conditions from the receiver, and the transmit-FIFO-empty flag. Two one-cycle strobes mark a write to the transmit holding register and a read of the identification register.

The four sources are ranked. Receive line status is first, then receive data at or above the trigger level, then character timeout, then transmit empty. The identification code shows the highest pending source. The receive sources are pure levels that follow their inputs in the same cycle. The transmit-empty source is the only one with state. It is raised when the armed condition (FIFO mode, transmit interrupt enabled, transmit FIFO empty) rises. It is dropped by a holding-register write, or by an identification read while it is the source being reported.

Top module: `uart_fifo_irq`

## Requirements
- R1: While reset is asserted and after its release with all inputs idle, `iid_o` is 4'h1 and `irq_o` is 0.
- R2: With `fifo_en_i` at 0, no source is reported: `iid_o` is 4'h1 whatever the other inputs are.
- R3: With `fifo_en_i` and `rx_ie_i` at 1, receive data (4'h4) is reported once `rx_count_i` is at or above the selected level. The `trig_sel_i` select maps 2'b00 to 1, 2'b01 to 4, 2'b10 to 8 and 2'b11 to 14 bytes.
- R4: Receive data stops being reported in the same cycle that `rx_count_i` falls below the selected level.
- R5: Line status (4'h6) is reported when `line_err_i`, `ls_ie_i` and `fifo_en_i` are all 1, and it ranks above every other source.
- R6: Character timeout (4'hC) needs `char_tmo_i`, `rx_ie_i` and `fifo_en_i` at 1. It ranks below receive data and above transmit empty.
- R7: When the armed condition (`fifo_en_i`, `tx_ie_i` and `tx_empty_i` all 1) rises, transmit empty (4'h2) becomes pending from the next cycle and stays pending while the condition holds.
- R8: A `thr_wr_i` pulse clears pending transmit empty from the next cycle on. It does not come back until the armed condition falls and rises again.
- R9: An `iir_rd_i` pulse clears transmit empty only when 4'h2 is the code shown in that cycle. A read while a higher source is shown leaves it pending.
- R10: Transmit empty is the lowest-ranked source.
- R11: `iid_o[0]` is 0 exactly when some source is reported, and `irq_o` is always the inverse of `iid_o[0]`.
- R12: When the armed condition falls, transmit empty stops being reported in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | FIFO mode enable |
| rx_ie_i | input | 1 | Receive data / timeout interrupt enable |
| ls_ie_i | input | 1 | Receive line-status interrupt enable |
| tx_ie_i | input | 1 | Transmit-empty interrupt enable |
| trig_sel_i | input | 2 | Receive trigger-level select |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| line_err_i | input | 1 | Receive line-error condition |
| char_tmo_i | input | 1 | Character-timeout condition |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 4 | Interrupt identification code |

## Verification
The hardest case to reach is an identification read that lands while transmit empty is pending but hidden behind a higher source. The read must leave the pending bit alone, and the bit then shows only after the higher source goes away. A directed sequence arms transmit empty and then raises the line error. It pulses the read, drops the error and expects 4'h2. Random cycles with frequent strobes and toggling enables also produce reads that collide with rising and falling armed conditions. A bench model of the pending bit covers those cases.

// File: rtl/uart_fifo_irq_pkg.sv
package uart_fifo_irq_pkg;

  typedef enum logic [3:0] {
    IID_NONE = 4'h1,
    IID_TXE  = 4'h2,
    IID_RDA  = 4'h4,
    IID_LSR  = 4'h6,
    IID_TMO  = 4'hC
  } iid_e;

  localparam int unsigned NUM_SRC = 4;

  // index order is the priority order, index 0 highest
  localparam int unsigned SRC_LSR = 0;
  localparam int unsigned SRC_RDA = 1;
  localparam int unsigned SRC_TMO = 2;
  localparam int unsigned SRC_TXE = 3;

  function automatic iid_e src_code(input int unsigned idx);
    case (idx)
      SRC_LSR: return IID_LSR;
      SRC_RDA: return IID_RDA;
      SRC_TMO: return IID_TMO;
      default: return IID_TXE;
    endcase
  endfunction

endpackage

// File: rtl/uart_fifo_irq_trig.sv
module uart_fifo_irq_trig #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned CNT_W   = $clog2(DEPTH + 1),
  parameter int unsigned TRIG_L0 = 1,
  parameter int unsigned TRIG_L1 = 4,
  parameter int unsigned TRIG_L2 = 8,
  parameter int unsigned TRIG_L3 = 14
) (
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             at_level_o
);

  localparam logic [CNT_W-1:0] LVL0 = CNT_W'(TRIG_L0);
  localparam logic [CNT_W-1:0] LVL1 = CNT_W'(TRIG_L1);
  localparam logic [CNT_W-1:0] LVL2 = CNT_W'(TRIG_L2);
  localparam logic [CNT_W-1:0] LVL3 = CNT_W'(TRIG_L3);

  logic [CNT_W-1:0] lvl;

  always_comb begin
    unique case (sel_i)
      2'b00:   lvl = LVL0;
      2'b01:   lvl = LVL1;
      2'b10:   lvl = LVL2;
      default: lvl = LVL3;
    endcase
  end

  assign at_level_o = (count_i >= lvl);

endmodule

// File: rtl/uart_fifo_irq_txe.sv
module uart_fifo_irq_txe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic wr_i,
  input  logic ack_i,
  output logic pend_o
);

  logic arm_q;
  logic pend_q;
  logic rise;

  assign rise = arm_i & ~arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      arm_q  <= arm_i;
      // clear strobes win over a coincident rise
      pend_q <= arm_i & (pend_q | rise) & ~wr_i & ~ack_i;
    end
  end

  // disarming hides the source at once
  assign pend_o = pend_q & arm_i;

endmodule

// File: rtl/uart_fifo_irq_prio.sv
module uart_fifo_irq_prio
  import uart_fifo_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output iid_e               iid_o
);

  iid_e code [NUM_SRC+1];

  assign code[NUM_SRC] = IID_NONE;

  // chain from lowest priority upward
  for (genvar g = NUM_SRC - 1; g >= 0; g--) begin : g_chain
    assign code[g] = req_i[g] ? src_code(g) : code[g+1];
  end

  assign iid_o = code[0];

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned CNT_W   = $clog2(DEPTH + 1),
  parameter int unsigned TRIG_L0 = 1,
  parameter int unsigned TRIG_L1 = 4,
  parameter int unsigned TRIG_L2 = 8,
  parameter int unsigned TRIG_L3 = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             rx_ie_i,
  input  logic             ls_ie_i,
  input  logic             tx_ie_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             line_err_i,
  input  logic             char_tmo_i,
  input  logic             tx_empty_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  output logic             irq_o,
  output logic [3:0]       iid_o
);

  logic               at_level;
  logic               tx_arm;
  logic               tx_pend;
  logic               tx_ack;
  logic [NUM_SRC-1:0] req;
  iid_e               iid;

  uart_fifo_irq_trig #(
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .TRIG_L0(TRIG_L0),
    .TRIG_L1(TRIG_L1),
    .TRIG_L2(TRIG_L2),
    .TRIG_L3(TRIG_L3)
  ) u_trig (
    .sel_i     (trig_sel_i),
    .count_i   (rx_count_i),
    .at_level_o(at_level)
  );

  assign tx_arm = fifo_en_i & tx_ie_i & tx_empty_i;
  assign tx_ack = iir_rd_i & (iid == IID_TXE);

  uart_fifo_irq_txe u_txe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (tx_arm),
    .wr_i  (thr_wr_i),
    .ack_i (tx_ack),
    .pend_o(tx_pend)
  );

  assign req[SRC_LSR] = fifo_en_i & ls_ie_i & line_err_i;
  assign req[SRC_RDA] = fifo_en_i & rx_ie_i & at_level;
  assign req[SRC_TMO] = fifo_en_i & rx_ie_i & char_tmo_i;
  assign req[SRC_TXE] = tx_pend;

  uart_fifo_irq_prio u_prio (
    .req_i(req),
    .iid_o(iid)
  );

  assign iid_o = iid;
  assign irq_o = |req;

endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned CNT_W   = $clog2(DEPTH + 1),
  parameter int unsigned TRIG_L0 = 1,
  parameter int unsigned TRIG_L1 = 4,
  parameter int unsigned TRIG_L2 = 8,
  parameter int unsigned TRIG_L3 = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             rx_ie_i,
  input logic             ls_ie_i,
  input logic             tx_ie_i,
  input logic [1:0]       trig_sel_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic             line_err_i,
  input logic             char_tmo_i,
  input logic             tx_empty_i,
  input logic             thr_wr_i,
  input logic             iir_rd_i,
  input logic             irq_o,
  input logic [3:0]       iid_o
);

  int unsigned lvl;
  logic        armed;
  logic        armed_prev;
  logic        ls_on;

  always_comb begin
    case (trig_sel_i)
      2'b00:   lvl = TRIG_L0;
      2'b01:   lvl = TRIG_L1;
      2'b10:   lvl = TRIG_L2;
      default: lvl = TRIG_L3;
    endcase
  end

  assign armed = fifo_en_i && tx_ie_i && tx_empty_i;
  assign ls_on = fifo_en_i && ls_ie_i && line_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_prev <= 1'b0;
    else         armed_prev <= armed;
  end

  p_masked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> (iid_o == 4'h1 && !irq_o));

  p_rda_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && rx_ie_i && !ls_on && int'(rx_count_i) >= int'(lvl)) |-> iid_o == 4'h4);

  p_ls_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_on |-> iid_o == 4'h6);

  p_tx_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !armed_prev && !thr_wr_i) |=> (!armed || irq_o));

  p_tx_wr_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> iid_o != 4'h2);

  p_irq_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o != iid_o[0]);

  p_disarm_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> iid_o != 4'h2);

endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W),
  .TRIG_L0(TRIG_L0),
  .TRIG_L1(TRIG_L1),
  .TRIG_L2(TRIG_L2),
  .TRIG_L3(TRIG_L3)
) u_chk (.*);

// File: tb/uart_fifo_irq_test.sv
module uart_fifo_irq_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int N_RANDOM   = 3000;

  logic             clk;
  logic             rst_n;
  logic             fifo_en, rx_ie, ls_ie, tx_ie;
  logic [1:0]       trig_sel;
  logic [CNT_W-1:0] rx_count;
  logic             line_err, char_tmo, tx_empty, thr_wr, iir_rd;
  logic             irq;
  logic [3:0]       iid;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  uart_fifo_irq #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .rx_ie_i(rx_ie),
    .ls_ie_i(ls_ie), .tx_ie_i(tx_ie), .trig_sel_i(trig_sel),
    .rx_count_i(rx_count), .line_err_i(line_err), .char_tmo_i(char_tmo),
    .tx_empty_i(tx_empty), .thr_wr_i(thr_wr), .iir_rd_i(iir_rd),
    .irq_o(irq), .iid_o(iid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int trig_level(input logic [1:0] s);
    case (s)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic tx_armed();
    return fifo_en && tx_ie && tx_empty;
  endfunction

  function automatic logic [3:0] exp_code(input logic txp);
    if (fifo_en && ls_ie && line_err) return 4'h6;
    if (fifo_en && rx_ie && int'(rx_count) >= trig_level(trig_sel)) return 4'h4;
    if (fifo_en && rx_ie && char_tmo) return 4'hC;
    if (txp && tx_armed()) return 4'h2;
    return 4'h1;
  endfunction

  // model of the transmit-empty pending bit
  logic m_pend, m_arm;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 1'b0;
      m_arm  <= 1'b0;
    end else begin
      m_pend <= tx_armed() && (m_pend || !m_arm) && !thr_wr &&
                !(iir_rd && exp_code(m_pend) == 4'h2);
      m_arm  <= tx_armed();
    end
  end

  task automatic check(input string tag, input logic [3:0] exp);
    n_vec++;
    if (iid !== exp || irq !== (exp != 4'h1)) begin
      n_fail++;
      $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b (R11)",
               tag, iid, irq, exp, exp != 4'h1);
    end
  endtask

  task automatic idle();
    fifo_en = 0; rx_ie = 0; ls_ie = 0; tx_ie = 0; trig_sel = 2'b00;
    rx_count = '0; line_err = 0; char_tmo = 0; tx_empty = 0;
    thr_wr = 0; iir_rd = 0;
  endtask

  // advance one edge; inputs change just after the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17_C3E1));
    idle();
    rst_n = 0;
    @(negedge clk);
    settle();
    check("R1 in reset", 4'h1);
    step();
    rst_n = 1;
    step();
    settle();
    check("R1 after reset", 4'h1);

    // R2: everything requested but FIFO mode off
    rx_ie = 1; ls_ie = 1; tx_ie = 1; line_err = 1; char_tmo = 1;
    tx_empty = 1; rx_count = CNT_W'(15);
    step(); settle();
    check("R2 masked", 4'h1);
    idle(); step();

    // R3 / R4 trigger levels
    fifo_en = 1; rx_ie = 1; trig_sel = 2'b01; rx_count = CNT_W'(3);
    settle(); check("R4 below 4", 4'h1);
    @(negedge clk); rx_count = CNT_W'(4);
    settle(); check("R3 at 4", 4'h4);
    @(negedge clk); rx_count = CNT_W'(3);
    settle(); check("R4 back below", 4'h1);
    @(negedge clk); trig_sel = 2'b11; rx_count = CNT_W'(13);
    settle(); check("R4 below 14", 4'h1);
    @(negedge clk); rx_count = CNT_W'(14);
    settle(); check("R3 at 14", 4'h4);
    @(negedge clk); trig_sel = 2'b10; rx_count = CNT_W'(8);
    settle(); check("R3 at 8", 4'h4);
    @(negedge clk); trig_sel = 2'b00; rx_count = CNT_W'(1);
    settle(); check("R3 at 1", 4'h4);

    // R5 line status
    @(negedge clk); ls_ie = 1; line_err = 1; char_tmo = 1;
    settle(); check("R5 over rda", 4'h6);
    @(negedge clk); ls_ie = 0;
    settle(); check("R5 needs enable", 4'h4);

    // R6 timeout
    @(negedge clk); rx_count = '0;
    settle(); check("R6 timeout", 4'hC);
    @(negedge clk); rx_ie = 0;
    settle(); check("R6 needs enable", 4'h1);
    @(negedge clk); idle(); fifo_en = 1; step();

    // R7 / R8 transmit empty
    tx_ie = 1; tx_empty = 1;
    step(); settle(); check("R7 set on rise", 4'h2);
    step(); settle(); check("R7 held", 4'h2);
    @(negedge clk); thr_wr = 1; step(); thr_wr = 0;
    settle(); check("R8 write clears", 4'h1);
    step(); settle(); check("R8 no re-raise", 4'h1);

    // R9 read while shown
    @(negedge clk); tx_empty = 0; step(); tx_empty = 1;
    step(); settle(); check("R7 rearm", 4'h2);
    @(negedge clk); iir_rd = 1; step(); iir_rd = 0;
    settle(); check("R9 read clears shown", 4'h1);

    // R9 / R10 read while hidden
    @(negedge clk); tx_empty = 0; step(); tx_empty = 1; step();
    ls_ie = 1; line_err = 1;
    settle(); check("R10 line over txe", 4'h6);
    @(negedge clk); iir_rd = 1; step(); iir_rd = 0; line_err = 0;
    settle(); check("R9 hidden read keeps", 4'h2);
    @(negedge clk); rx_ie = 1; char_tmo = 1;
    settle(); check("R10 timeout over txe", 4'hC);
    @(negedge clk); char_tmo = 0; rx_ie = 0;

    // R12 disarm
    @(negedge clk); tx_ie = 0;
    settle(); check("R12 disarm drops", 4'h1);
    @(negedge clk); tx_ie = 1;
    settle(); check("R7 not yet pending", 4'h1);
    step(); settle(); check("R7 re-enable", 4'h2);

    // random mix, model-checked
    for (int i = 0; i < N_RANDOM; i++) begin
      @(negedge clk);
      fifo_en  = ($urandom % 8) != 0;
      rx_ie    = $urandom % 2;
      ls_ie    = $urandom % 2;
      tx_ie    = ($urandom % 4) != 0;
      trig_sel = 2'($urandom % 4);
      rx_count = CNT_W'($urandom % (DEPTH + 1));
      line_err = ($urandom % 5) == 0;
      char_tmo = ($urandom % 4) == 0;
      tx_empty = ($urandom % 3) != 0;
      thr_wr   = ($urandom % 6) == 0;
      iir_rd   = ($urandom % 4) == 0;
      settle();
      check("R3-R12 random", exp_code(m_pend));
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    end
    $finish;
  end

endmodule